// File: doc/BRIEF.md
# Inverted Bit-Field Insert Unit

This execution unit belongs to a 16-bit datapath. It holds a small register file. On each execute strobe it reads a destination operand, a source operand and a control operand from that register file. It then writes the destination back with one bit field replaced by the inverted low bits of the source. The low byte of the control operand holds two four-bit codes. The high code selects the field length and the low code selects where the field starts in the destination. Destination bits outside the field pass through unchanged. Field bits that would fall past the most significant bit are lost, so nothing wraps around.

The register file has a second write path, used by the rest of the datapath to deposit operands, and an observation read port. Register 0 is a hard zero. Naming it as the source therefore inserts a run of ones, which makes the operation a "set this bit range" primitive. Each execute also updates four condition flags: negative, zero, overflow and carry. The negative and zero flags are computed from the merged value, overflow is forced low, and carry is left alone.

Top module: `bfi_unit`

## Requirements
- R1: The field length is the control operand's bits [7:4] plus one, so an execute replaces between 1 and 16 destination bits.
- R2: The start position is the control operand's bits [3:0]; control bits [15:8] have no effect on the result or the flags.
- R3: Destination bit (start + k), for k from 0 to the field length minus one, takes the inverse of source bit k; every other destination bit keeps its value.
- R4: When start plus the length code exceeds 15, field bits that would land above bit 15 are dropped, and the low destination bits are left unchanged.
- R5: On an execute, flag_n takes bit 15 of the merged value.
- R6: On an execute, flag_z is 1 exactly when the merged 16-bit value is 0x0000.
- R7: On an execute, flag_v is cleared and flag_c keeps its previous value.
- R8: Register 0 always reads 0x0000, and writes to it from either write path are discarded. With register 0 as the source, the field is filled with ones. With register 0 as the destination, the flags still follow the merged value.
- R9: Registers and flags change only at a rising clock edge. Flags change only when exec_en is high, and registers change only when exec_en or ld_en is high.
- R10: A synchronous active-high rst clears all eight registers and all four flags.
- R11: With ld_en high and exec_en low, ld_data is written into register ld_sel. When both are high in the same cycle, the execute writes and the load is discarded.
- R12: rd_data shows the current content of register rd_sel without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Execute strobe for the insert operation |
| dst_sel | input | 3 | Destination register index (read and written) |
| src_sel | input | 3 | Source register index |
| ctl_sel | input | 3 | Control register index (length and start codes) |
| ld_en | input | 1 | Operand load strobe |
| ld_sel | input | 3 | Register index written by a load |
| ld_data | input | 16 | Value written by a load |
| rd_sel | input | 3 | Observation read index |
| rd_data | output | 16 | Content of register rd_sel |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The bench runs every one of the 256 length and start combinations against three destination and source patterns, and compares each result with a bit-by-bit model. This exposes an off-by-one in the length that would move one bit too many or too few. It also exposes a wrapping shift, which would corrupt the low destination bits whenever start plus length code exceeds 15. The all-zero-source pattern counts inserted ones, and the zero-result pattern drives flag_z high, so a flag taken from the wrong value would disagree. Directed cases cover a nonzero control upper byte that a careless decoder would treat as length bits, register 0 as source and destination, a load colliding with an execute, where a wrong priority corrupts a bystander register, and idle cycles in which a leaky enable would disturb the flags.

// File: rtl/bfi_pkg.sv
package bfi_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } bfi_flags_t;

    localparam bfi_flags_t BFI_FLAGS_RESET = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

endpackage

// File: rtl/bfi_regfile.sv
module bfi_regfile #(
    parameter int DATA_W = 16,
    parameter int NREGS  = 8,
    parameter int NRD    = 4,
    localparam int SEL_W = $clog2(NREGS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [SEL_W-1:0]              waddr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [NRD-1:0][SEL_W-1:0]     raddr,
    output logic [NRD-1:0][DATA_W-1:0]    rdata
);

    typedef logic [NREGS-1:0][DATA_W-1:0] bank_t;

    bank_t regs_d;
    bank_t regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we && (waddr != '0)) begin
            regs_d[waddr] = wdata;
        end
        regs_d[0] = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = regs_q[raddr[g]];
    end

endmodule

// File: rtl/bfi_merge.sv
module bfi_merge #(
    parameter int DATA_W = 16,
    localparam int CODE_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] dst,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] ctl,
    output logic [DATA_W-1:0] result
);

    logic [CODE_W-1:0] len_code;
    logic [CODE_W-1:0] start;
    logic [DATA_W-1:0] run;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] inv_shifted;
    logic              unused_ctl_hi;

    assign len_code = ctl[2*CODE_W-1:CODE_W];
    assign start    = ctl[CODE_W-1:0];

    assign unused_ctl_hi = ^ctl[DATA_W-1:2*CODE_W];

    always_comb begin
        run         = {DATA_W{1'b1}} >> (DATA_W - 1 - int'(len_code));
        mask        = run << start;
        inv_shifted = (~src) << start;
        result      = (dst & ~mask) | (inv_shifted & mask);
    end

endmodule

// File: rtl/bfi_unit.sv
module bfi_unit #(
    parameter int DATA_W = 16,
    parameter int NREGS  = 8,
    localparam int SEL_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_en,
    input  logic [SEL_W-1:0]  dst_sel,
    input  logic [SEL_W-1:0]  src_sel,
    input  logic [SEL_W-1:0]  ctl_sel,
    input  logic              ld_en,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c
);
    import bfi_pkg::*;

    localparam int NRD = 4;

    logic [NRD-1:0][SEL_W-1:0]  rf_raddr;
    logic [NRD-1:0][DATA_W-1:0] rf_rdata;
    logic                       rf_we;
    logic [SEL_W-1:0]           rf_waddr;
    logic [DATA_W-1:0]          rf_wdata;
    logic [DATA_W-1:0]          merged;

    bfi_flags_t flags_d;
    bfi_flags_t flags_q;

    assign rf_raddr = {rd_sel, ctl_sel, src_sel, dst_sel};

    bfi_regfile #(
        .DATA_W (DATA_W),
        .NREGS  (NREGS),
        .NRD    (NRD)
    ) i_regfile (
        .clk    (clk),
        .rst    (rst),
        .we     (rf_we),
        .waddr  (rf_waddr),
        .wdata  (rf_wdata),
        .raddr  (rf_raddr),
        .rdata  (rf_rdata)
    );

    bfi_merge #(
        .DATA_W (DATA_W)
    ) i_merge (
        .dst    (rf_rdata[0]),
        .src    (rf_rdata[1]),
        .ctl    (rf_rdata[2]),
        .result (merged)
    );

    always_comb begin
        rf_we    = exec_en | ld_en;
        rf_waddr = exec_en ? dst_sel : ld_sel;
        rf_wdata = exec_en ? merged  : ld_data;

        flags_d = flags_q;
        if (exec_en) begin
            flags_d.n = merged[DATA_W-1];
            flags_d.z = (merged == '0);
            flags_d.v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= BFI_FLAGS_RESET;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign rd_data = rf_rdata[3];
    assign flag_n  = flags_q.n;
    assign flag_z  = flags_q.z;
    assign flag_v  = flags_q.v;
    assign flag_c  = flags_q.c;

endmodule

// File: rtl/bfi_checker.sv
module bfi_checker #(
    parameter int DATA_W = 16,
    parameter int SEL_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              exec_en,
    input logic [SEL_W-1:0]  dst_sel,
    input logic              ld_en,
    input logic [SEL_W-1:0]  ld_sel,
    input logic [DATA_W-1:0] ld_data,
    input logic [SEL_W-1:0]  rd_sel,
    input logic [DATA_W-1:0] rd_data,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_v,
    input logic              flag_c
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!flag_n && !flag_z && !flag_v && !flag_c && rd_data == '0)); // R10

    AST_REG0_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == '0) |-> (rd_data == '0)); // R8

    AST_V_CLEARED: assert property (@(posedge clk) disable iff (rst)
        exec_en |=> !flag_v); // R7

    AST_C_HELD: assert property (@(posedge clk) disable iff (rst)
        exec_en |=> $stable(flag_c)); // R7

    AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !exec_en |=> $stable({flag_n, flag_z, flag_v, flag_c})); // R9

    AST_NZ_TRACK: assert property (@(posedge clk) disable iff (rst)
        (exec_en && dst_sel != '0) |=>
            ((rd_sel != $past(dst_sel)) ||
             (flag_z == (rd_data == '0) && flag_n == rd_data[DATA_W-1]))); // R5 R6

    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (rst)
        (ld_en && !exec_en && ld_sel != '0) |=>
            ((rd_sel != $past(ld_sel)) || (rd_data == $past(ld_data)))); // R11

endmodule

bind bfi_unit bfi_checker #(
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W)
) i_chk (
    .clk     (clk),
    .rst     (rst),
    .exec_en (exec_en),
    .dst_sel (dst_sel),
    .ld_en   (ld_en),
    .ld_sel  (ld_sel),
    .ld_data (ld_data),
    .rd_sel  (rd_sel),
    .rd_data (rd_data),
    .flag_n  (flag_n),
    .flag_z  (flag_z),
    .flag_v  (flag_v),
    .flag_c  (flag_c)
);

// File: tb/test_bfi_unit.sv
`timescale 1ns/100ps
module test_bfi_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exec_en = 1'b0;
    logic [2:0]  dst_sel = '0;
    logic [2:0]  src_sel = '0;
    logic [2:0]  ctl_sel = '0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_sel = '0;
    logic [15:0] ld_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        flag_n, flag_z, flag_v, flag_c;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bfi_unit i_bfi_unit (
        .clk(clk), .rst(rst), .exec_en(exec_en),
        .dst_sel(dst_sel), .src_sel(src_sel), .ctl_sel(ctl_sel),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [15:0] d, input logic [15:0] s,
                                          input logic [15:0] c);
        logic [15:0] r;
        int len_code = int'(c[7:4]);
        int start    = int'(c[3:0]);
        for (int i = 0; i < 16; i++) begin
            if (i >= start && i <= start + len_code) r[i] = ~s[i - start];
            else                                     r[i] = d[i];
        end
        return r;
    endfunction

    task automatic load(input logic [2:0] sel, input logic [15:0] data);
        ld_en = 1'b1; ld_sel = sel; ld_data = data;
        @(posedge clk); #1;
        ld_en = 1'b0;
    endtask

    task automatic execute(input logic [2:0] d, input logic [2:0] s, input logic [2:0] c);
        exec_en = 1'b1; dst_sel = d; src_sel = s; ctl_sel = c;
        @(posedge clk); #1;
        exec_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] sel, output logic [15:0] val);
        rd_sel = sel;
        #0.5;
        val = rd_data;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v, exp, dpat, spat, ctl, keep;
        logic [15:0] dpats [3];
        logic [15:0] spats [3];
        dpats[0] = 16'hA5C3; spats[0] = 16'h3C96;
        dpats[1] = 16'h0000; spats[1] = 16'h0000;
        dpats[2] = 16'h0000; spats[2] = 16'hFFFF;

        repeat (3) @(posedge clk);
        #1; rst = 1'b0;

        // R10: reset state
        for (int r = 0; r < 8; r++) begin
            peek(3'(r), v);
            check("R10", {16'h0, v}, 32'h0);
        end
        check("R10", {flag_n, flag_z, flag_v, flag_c}, 32'h0);

        // R12: load then immediate observation
        load(3'd5, 16'h6A17);
        peek(3'd5, v);
        check("R12", {16'h0, v}, 32'h6A17);

        // Sweep all length/start codes
        for (int p = 0; p < 3; p++) begin
            for (int w = 0; w < 16; w++) begin
                for (int o = 0; o < 16; o++) begin
                    dpat = dpats[p]; spat = spats[p];
                    ctl  = {8'((w * 37 + o * 11) & 255), 4'(w), 4'(o)};
                    load(3'd1, dpat);
                    load(3'd2, spat);
                    load(3'd3, ctl);
                    execute(3'd1, 3'd2, 3'd3);
                    exp = model(dpat, spat, ctl);
                    peek(3'd1, v);
                    if (o + w > 15) check("R4", {16'h0, v}, {16'h0, exp});
                    else            check("R3", {16'h0, v}, {16'h0, exp});
                    if (p == 1)
                        check("R1", $countones(v), ((w + 1) < (16 - o)) ? (w + 1) : (16 - o));
                    check("R5", {31'h0, flag_n}, {31'h0, exp[15]});
                    check("R6", {31'h0, flag_z}, {31'h0, exp == 16'h0});
                    check("R7", {flag_v, flag_c}, 32'h0);
                end
            end
        end

        // R2: control upper byte has no effect
        load(3'd1, 16'h1234); load(3'd2, 16'h00F0); load(3'd3, 16'h0074);
        execute(3'd1, 3'd2, 3'd3);
        peek(3'd1, keep);
        load(3'd1, 16'h1234); load(3'd3, 16'hFF74);
        execute(3'd1, 3'd2, 3'd3);
        peek(3'd1, v);
        check("R2", {16'h0, v}, {16'h0, keep});
        check("R2", {16'h0, v}, {16'h0, model(16'h1234, 16'h00F0, 16'h0074)});

        // R8: register 0 as source sets ones
        load(3'd1, 16'h0000); load(3'd3, 16'h0052);
        execute(3'd1, 3'd0, 3'd3);
        peek(3'd1, v);
        check("R8", {16'h0, v}, 32'h00FC);

        // R8: register 0 as destination, write dropped, flags follow result
        load(3'd3, 16'h00F0);
        execute(3'd0, 3'd0, 3'd3);
        peek(3'd0, v);
        check("R8", {16'h0, v}, 32'h0);
        check("R8", {flag_n, flag_z}, 32'h2);
        load(3'd0, 16'h1234);
        peek(3'd0, v);
        check("R8", {16'h0, v}, 32'h0);

        // R9: no execute, flags and destination hold
        load(3'd1, 16'h8000); load(3'd2, 16'hFFFF); load(3'd3, 16'h0000);
        execute(3'd1, 3'd2, 3'd3);
        check("R9", {flag_n, flag_z}, 32'h2);
        dst_sel = 3'd1; src_sel = 3'd0; ctl_sel = 3'd3;
        repeat (4) @(posedge clk);
        #1;
        load(3'd6, 16'h0000);
        peek(3'd1, v);
        check("R9", {16'h0, v}, 32'h8000);
        check("R9", {flag_n, flag_z, flag_v, flag_c}, 32'h8);

        // R11: load colliding with execute is discarded
        load(3'd4, 16'h1111);
        load(3'd1, 16'h0000); load(3'd3, 16'h0030);
        ld_en = 1'b1; ld_sel = 3'd4; ld_data = 16'hBEEF;
        execute(3'd1, 3'd0, 3'd3);
        ld_en = 1'b0;
        peek(3'd4, v);
        check("R11", {16'h0, v}, 32'h1111);
        peek(3'd1, v);
        check("R11", {16'h0, v}, 32'h000F);
        load(3'd4, 16'h2222);
        peek(3'd4, v);
        check("R11", {16'h0, v}, 32'h2222);

        // R10: reset mid-run
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        for (int r = 0; r < 8; r++) begin
            peek(3'(r), v);
            check("R10", {16'h0, v}, 32'h0);
        end
        check("R10", {flag_n, flag_z, flag_v, flag_c}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule